// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two 8-bit words, P and Q. It drives two active-high decisions: P above Q, and P below Q. It has no equality output. A mode input selects the comparison at run time. In plain binary mode the words are unsigned. In two's-complement mode the top bit is the sign.

The P operand passes through a holding stage. While the hold-enable input is high, P goes straight to the comparison. While hold-enable is low, the comparison uses the P value that was captured at the last rising clock edge with the enable high. An asynchronous active-low reset clears the held value to zero. The Q operand always feeds the comparison directly.

Two cascade inputs decide the result when the words match. Stages chain from least to most significant by wiring one stage's outputs into the next stage's cascade inputs, with no glue logic between them. Only the top stage of a chain uses two's-complement mode. A lone stage ties both cascade inputs low.

Top module: `mag_cmp_top`

## Requirements
- R1: With modeSigned low and differing words, gtOut is 1 exactly when P exceeds Q as unsigned numbers, and ltOut is 1 exactly when P is below Q.
- R2: With modeSigned high, the words are two's-complement values with bit 7 as the sign, so any word with bit 7 set ranks below any word with bit 7 clear.
- R3: When the effective P equals Q, gtOut copies casGtIn and ltOut copies casLtIn, in either mode and including the case where both are high.
- R4: gtOut and ltOut are never high together unless both cascade inputs are high.
- R5: While pHoldEn is high, the comparison uses pIn directly, with no clock needed for a change of pIn to show on the outputs.
- R6: While pHoldEn is low, the comparison uses the pIn value captured at the last rising clock edge that saw pHoldEn high, and later changes of pIn have no effect.
- R7: Asserting rstN low clears the held P value to zero at once, without a clock.
- R8: qIn is never held: with pHoldEn low, a change of qIn changes the outputs at once.
- R9: Two stages chain into a 16-bit comparator. The low stage runs in unsigned mode with cascade inputs low, and its outputs feed the high stage's cascade inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that captures P into the hold register |
| rstN | input | 1 | Asynchronous active-low reset; clears held P |
| pHoldEn | input | 1 | High: P passes through; low: held P is used |
| pIn | input | 8 | Operand P |
| qIn | input | 8 | Operand Q, always used directly |
| modeSigned | input | 1 | 0 = unsigned comparison, 1 = two's-complement comparison |
| casGtIn | input | 1 | Greater decision from the less significant stage |
| casLtIn | input | 1 | Less decision from the less significant stage |
| gtOut | output | 1 | P greater than Q |
| ltOut | output | 1 | P less than Q |

## Verification
The vector table aims at the words where the two modes disagree, such as 0x80 against 0x7F and -1 against 1. A design that ignored the mode, or that inverted the wrong bit, would give the unsigned answer in both modes. Equal words are tried with all four cascade patterns, and with cascade inputs high against differing words, to catch a design that lets the cascade override a real difference. Directed tests change pIn after the hold closes, reset with the hold closed, and move qIn while P is held, so that a design that latches Q or ignores the hold fails. A 16-bit chain with a carry across the 0x80/0x7F byte boundary exposes a design that handles the sign in the wrong stage.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic captureP;   // load hold register this edge
    logic selDirect;  // feed comparison from pIn rather than the hold register
    logic signedCmp;  // two's-complement ordering
  } cmpStrobes_t;
endpackage

// File: rtl/mag_cmp_ctrl.sv
module mag_cmp_ctrl
  import mag_cmp_pkg::*;
(
  input  logic        pHoldEn,
  input  logic        modeSigned,
  output cmpStrobes_t strobes
);
  always_comb begin
    strobes.captureP  = pHoldEn;
    strobes.selDirect = pHoldEn;
    strobes.signedCmp = modeSigned;
  end
endmodule

// File: rtl/mag_cmp_datapath.sv
module mag_cmp_datapath
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobes_t      strobes,
  input  logic [WIDTH-1:0] pIn,
  input  logic [WIDTH-1:0] qIn,
  input  logic             casGtIn,
  input  logic             casLtIn,
  output logic             gtOut,
  output logic             ltOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] pHeld;
  logic [WIDTH-1:0] pEff;
  logic [WIDTH-1:0] pKey;
  logic [WIDTH-1:0] qKey;
  logic [WIDTH-1:0] bitGt;
  logic [WIDTH-1:0] bitLt;
  logic             wordGt;
  logic             wordLt;

  // hold register, cleared asynchronously
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pHeld <= '0;
    else if (strobes.captureP) pHeld <= pIn;
  end

  assign pEff = strobes.selDirect ? pIn : pHeld;

  // flipping the sign bit maps two's-complement order onto unsigned order
  assign pKey = {pEff[MSB] ^ strobes.signedCmp, pEff[MSB-1:0]};
  assign qKey = {qIn[MSB]  ^ strobes.signedCmp, qIn[MSB-1:0]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitGt[i] = pKey[i] & ~qKey[i];
    assign bitLt[i] = ~pKey[i] & qKey[i];
  end

  // first differing bit from the top decides
  always_comb begin
    wordGt = 1'b0;
    wordLt = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bitGt[i] | bitLt[i]) begin
        wordGt = bitGt[i];
        wordLt = bitLt[i];
      end
    end
  end

  always_comb begin
    if (wordGt | wordLt) begin
      gtOut = wordGt;
      ltOut = wordLt;
    end else begin
      gtOut = casGtIn;
      ltOut = casLtIn;
    end
  end
endmodule

// File: rtl/mag_cmp_top.sv
module mag_cmp_top
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pHoldEn,
  input  logic [WIDTH-1:0] pIn,
  input  logic [WIDTH-1:0] qIn,
  input  logic             modeSigned,
  input  logic             casGtIn,
  input  logic             casLtIn,
  output logic             gtOut,
  output logic             ltOut
);
  cmpStrobes_t strobes;

  mag_cmp_ctrl u_ctrl (
    .pHoldEn    (pHoldEn),
    .modeSigned (modeSigned),
    .strobes    (strobes)
  );

  mag_cmp_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pIn     (pIn),
    .qIn     (qIn),
    .casGtIn (casGtIn),
    .casLtIn (casLtIn),
    .gtOut   (gtOut),
    .ltOut   (ltOut)
  );
endmodule

// File: rtl/mag_cmp_checker.sv
module mag_cmp_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pHoldEn,
  input logic [WIDTH-1:0] pIn,
  input logic [WIDTH-1:0] qIn,
  input logic             modeSigned,
  input logic             casGtIn,
  input logic             casLtIn,
  input logic             gtOut,
  input logic             ltOut
);
  assert_unsigned_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pHoldEn && !modeSigned && (pIn > qIn)) |-> (gtOut && !ltOut));

  assert_signed_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pHoldEn && modeSigned && ($signed(pIn) < $signed(qIn))) |-> (ltOut && !gtOut));

  assert_equal_passes_cascade_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pHoldEn && (pIn == qIn)) |-> ((gtOut == casGtIn) && (ltOut == casLtIn)));

  assert_exclusive_outputs_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(casGtIn && casLtIn) |-> !(gtOut && ltOut));

  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!pHoldEn && $past(!pHoldEn) && $stable(qIn) && $stable(modeSigned)
     && $stable(casGtIn) && $stable(casLtIn)) |-> ($stable(gtOut) && $stable(ltOut)));
endmodule

bind mag_cmp_top mag_cmp_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pHoldEn    (pHoldEn),
  .pIn        (pIn),
  .qIn        (qIn),
  .modeSigned (modeSigned),
  .casGtIn    (casGtIn),
  .casLtIn    (casLtIn),
  .gtOut      (gtOut),
  .ltOut      (ltOut)
);

// File: tb/mag_cmp_top_tb.sv
module mag_cmp_top_tb;
  localparam int PERIOD = 10;
  localparam int NVEC   = 13;
  // {p, q, modeSigned, casGt, casLt, expGt, expLt}
  localparam logic [20:0] VEC [NVEC] = '{
    {8'h05, 8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R1
    {8'h03, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1
    {8'h80, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R1
    {8'h80, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R2
    {8'hFF, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R2
    {8'hFE, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R2
    {8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2
    {8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R1
    {8'hAA, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
    {8'hAA, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3
    {8'h3C, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3
    {8'h3C, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R3
    {8'h12, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}   // R4
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pHoldEn = 1'b0;
  logic [7:0] pIn = '0, qIn = '0;
  logic modeSigned = 1'b0, casGtIn = 1'b0, casLtIn = 1'b0;
  logic gtOut, ltOut;

  // 16-bit chain
  logic [15:0] aWide = '0, bWide = '0;
  logic loGt, loLt, hiGt, hiLt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mag_cmp_top u_dut (
    .clk(clk), .rstN(rstN), .pHoldEn(pHoldEn), .pIn(pIn), .qIn(qIn),
    .modeSigned(modeSigned), .casGtIn(casGtIn), .casLtIn(casLtIn),
    .gtOut(gtOut), .ltOut(ltOut)
  );

  mag_cmp_top u_lsb (
    .clk(clk), .rstN(rstN), .pHoldEn(1'b1), .pIn(aWide[7:0]), .qIn(bWide[7:0]),
    .modeSigned(1'b0), .casGtIn(1'b0), .casLtIn(1'b0),
    .gtOut(loGt), .ltOut(loLt)
  );

  mag_cmp_top u_msb (
    .clk(clk), .rstN(rstN), .pHoldEn(1'b1), .pIn(aWide[15:8]), .qIn(bWide[15:8]),
    .modeSigned(1'b1), .casGtIn(loGt), .casLtIn(loLt),
    .gtOut(hiGt), .ltOut(hiLt)
  );

  task automatic check(input string req, input logic aGt, input logic aLt,
                       input logic eGt, input logic eLt);
    checks++;
    if (aGt !== eGt || aLt !== eLt) begin
      errors++;
      $display("FAIL %s: got gt=%b lt=%b, expected gt=%b lt=%b", req, aGt, aLt, eGt, eLt);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    // reset state: held P is zero, hold closed
    qIn = 8'h00;
    #2;
    check("R7 reset equal", gtOut, ltOut, 1'b0, 1'b0);
    qIn = 8'h01;
    #1;
    check("R7 reset below", gtOut, ltOut, 1'b0, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // vector table, hold open (R5: no clock between drive and sample)
    pHoldEn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {pIn, qIn, modeSigned, casGtIn, casLtIn} = VEC[i][20:2];
      #1;
      check($sformatf("R1/R2/R3/R4/R5 vec %0d", i), gtOut, ltOut, VEC[i][1], VEC[i][0]);
    end
    {modeSigned, casGtIn, casLtIn} = 3'b000;

    // R6: capture 0x40, then close hold and move pIn
    @(negedge clk);
    pIn = 8'h40; qIn = 8'h20;
    @(negedge clk);
    pHoldEn = 1'b0;
    pIn = 8'h01;
    #1;
    check("R6 held value used", gtOut, ltOut, 1'b1, 1'b0);
    @(negedge clk);
    pIn = 8'hFF;
    @(negedge clk);
    check("R6 pIn ignored while held", gtOut, ltOut, 1'b1, 1'b0);

    // R8: qIn acts at once while P held
    qIn = 8'h50;
    #1;
    check("R8 qIn above held", gtOut, ltOut, 1'b0, 1'b1);
    qIn = 8'h40;
    #1;
    check("R8 qIn equal held", gtOut, ltOut, 1'b0, 1'b0);

    // R7: asynchronous clear mid-cycle, hold closed
    @(negedge clk);
    #2;
    rstN = 1'b0;
    #1;
    check("R7 async clear", gtOut, ltOut, 1'b0, 1'b1);
    qIn = 8'h00;
    #1;
    check("R7 cleared equals zero", gtOut, ltOut, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R9: 16-bit chain
    aWide = 16'h1234; bWide = 16'h1230;
    #1;
    check("R9 low byte decides", hiGt, hiLt, 1'b1, 1'b0);
    aWide = 16'hFF00; bWide = 16'h0001;
    #1;
    check("R9 signed top byte", hiGt, hiLt, 1'b0, 1'b1);
    aWide = 16'h1280; bWide = 16'h127F;
    #1;
    check("R9 low byte unsigned", hiGt, hiLt, 1'b1, 1'b0);
    aWide = 16'h8000; bWide = 16'h7FFF;
    #1;
    check("R9 negative wide", hiGt, hiLt, 1'b0, 1'b1);
    aWide = 16'hC3C3; bWide = 16'hC3C3;
    #1;
    check("R9 equal wide", hiGt, hiLt, 1'b0, 1'b0);

    finish_run();
  end
endmodule